// File: doc/BRIEF.md
# Delta-Sigma IQ-to-Polar Encoder

This block turns a stream of signed in-phase and quadrature baseband samples into a coarse polar code. The code is a 2-bit amplitude and a 3-bit phase. The block does not compute a vector angle or a magnitude. Each of the two inputs goes through its own first-order delta-sigma modulator, which reduces it to one of three levels: -1, 0 or +1. The pair of levels can take only nine values. A fixed nine-entry table turns that pair into the amplitude and phase codes.

The encoder sits between the baseband sample source and a later polar modulator. A sample enters when `in_valid` is high. The matching code appears on the registered outputs exactly one clock later, together with `out_valid`. The quantization noise of each modulator is pushed to high frequencies, so the local average of the ternary stream tracks the input.

Top module: `iq_polar_encoder`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears both modulator accumulators, `out_valid`, `out_amp` and `out_phase` to zero. The first valid sample after reset is therefore quantized from a zero accumulator.
- R2: `out_valid` equals the value `in_valid` had one clock earlier. A code is produced for every valid sample and for nothing else.
- R3: With full scale F = 2^(SAMPLE_W-1) and H = F/2, each modulator forms v = acc + x. It outputs +1 when v > H, -1 when v < -H, and 0 otherwise, so v equal to ±H gives 0. The new accumulator is v - F, v + F or v respectively.
- R4: `out_amp` is 0 when both levels are 0, 1 when exactly one level is non-zero, and 2 when both levels are non-zero.
- R5: For a non-zero pair (i,q), `out_phase` counts counter-clockwise in 45 degree steps: (+1,0)=0, (+1,+1)=1, (0,+1)=2, (-1,+1)=3, (-1,0)=4, (-1,-1)=5, (0,-1)=6, (+1,-1)=7.
- R6: When both levels are 0, `out_phase` keeps the value it had before that sample.
- R7: `out_amp` never takes the value 3. A diagonal amplitude (2) always comes with an odd phase, and an on-axis amplitude (1) with an even phase.
- R8: A cycle with `in_valid` low changes neither accumulator, `out_amp` nor `out_phase`, whatever the sample inputs carry.
- R9: Each error accumulator stays within [-H, +H]. As a result, a constant most-negative input (-F on both lanes) yields the level pair (-1,-1) on every sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe for `in_i` and `in_q` |
| in_i | input | SAMPLE_W | Signed in-phase sample, two's complement |
| in_q | input | SAMPLE_W | Signed quadrature sample, two's complement |
| out_valid | output | 1 | Code strobe, one cycle after `in_valid` |
| out_amp | output | 2 | Amplitude code (0, 1 or 2) |
| out_phase | output | 3 | Phase code in 45 degree steps |

## Verification
The bench builds the encoder with SAMPLE_W = 4, so full scale is 8 and the thresholds sit at ±4. At that width all 256 pairs of input values can be swept, each over several consecutive samples with the accumulators carried along. A bench model computes the accumulator walk, the threshold ties at exactly ±4, and the hold of the phase on the origin pair. Idle gaps carry junk inputs. The bench also applies resets in the middle of a run and a sustained most-negative input.

// File: rtl/iqp_pkg.sv
package iqp_pkg;

  typedef enum logic [1:0] {
    TR_ZERO = 2'b00,
    TR_POS  = 2'b01,
    TR_NEG  = 2'b11
  } trit_t;

  localparam int AMP_W = 2;
  localparam int PH_W  = 3;
  localparam int LUT_N = 9;
  localparam int LANES = 2;

  typedef struct packed {
    logic [AMP_W-1:0] amp;
    logic [PH_W-1:0]  ph;
    logic             origin;
  } polar_t;

  // table row/column index of a level: -1 -> 0, 0 -> 1, +1 -> 2
  function automatic logic [1:0] trit_idx(trit_t t);
    case (t)
      TR_NEG:  return 2'd0;
      TR_POS:  return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/tern_dsm.sv
module tern_dsm
  import iqp_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] sample,
  output trit_t        level
);

  localparam int AW = W + 2;
  localparam logic signed [AW-1:0] FULL = AW'(1) <<< (W - 1);
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (W - 2);

  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] sum;
  logic signed [AW-1:0] acc_d;

  always_comb begin
    sum = acc_q + AW'($signed(sample));
    if (sum > HALF) begin
      level = TR_POS;
      acc_d = sum - FULL;
    end else if (sum < -HALF) begin
      level = TR_NEG;
      acc_d = sum + FULL;
    end else begin
      level = TR_ZERO;
      acc_d = sum;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (step) acc_q <= acc_d;
  end

  // R9
  acc_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_q <= HALF) && (acc_q >= -HALF));

  // R8
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(acc_q));

endmodule

// File: rtl/polar_map.sv
module polar_map
  import iqp_pkg::*;
(
  input  trit_t  t_i,
  input  trit_t  t_q,
  output polar_t code
);

  function automatic polar_t build_entry(int k);
    polar_t e;
    int ii;
    int qq;
    ii = k / 3 - 1;
    qq = k % 3 - 1;
    e.amp    = AMP_W'(int'(ii != 0) + int'(qq != 0));
    e.origin = (ii == 0) && (qq == 0);
    if      (ii ==  1 && qq ==  0) e.ph = 3'd0;
    else if (ii ==  1 && qq ==  1) e.ph = 3'd1;
    else if (ii ==  0 && qq ==  1) e.ph = 3'd2;
    else if (ii == -1 && qq ==  1) e.ph = 3'd3;
    else if (ii == -1 && qq ==  0) e.ph = 3'd4;
    else if (ii == -1 && qq == -1) e.ph = 3'd5;
    else if (ii ==  0 && qq == -1) e.ph = 3'd6;
    else if (ii ==  1 && qq == -1) e.ph = 3'd7;
    else                           e.ph = 3'd0;
    return e;
  endfunction

  polar_t     rom [0:LUT_N-1];
  logic [3:0] idx;

  for (genvar k = 0; k < LUT_N; k++) begin : g_rom
    assign rom[k] = build_entry(k);
  end

  assign idx  = 4'(trit_idx(t_i)) * 4'd3 + 4'(trit_idx(t_q));
  assign code = rom[idx];

endmodule

// File: rtl/iq_polar_encoder.sv
module iq_polar_encoder
  import iqp_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_i,
  input  logic [SAMPLE_W-1:0] in_q,
  output logic                out_valid,
  output logic [AMP_W-1:0]    out_amp,
  output logic [PH_W-1:0]     out_phase
);

  logic [SAMPLE_W-1:0] lane_in [LANES];
  trit_t               lane_lv [LANES];
  polar_t              map_code;

  assign lane_in[0] = in_i;
  assign lane_in[1] = in_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tern_dsm #(.W(SAMPLE_W)) u_dsm (
      .clk    (clk),
      .rst    (rst),
      .step   (in_valid),
      .sample (lane_in[g]),
      .level  (lane_lv[g])
    );
  end

  polar_map u_map (
    .t_i  (lane_lv[0]),
    .t_q  (lane_lv[1]),
    .code (map_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_amp   <= '0;
      out_phase <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_amp <= map_code.amp;
        if (!map_code.origin) out_phase <= map_code.ph;
      end
    end
  end

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R7
  amp_legal_chk: assert property (@(posedge clk) disable iff (rst)
    out_amp != 2'd3);

  // R7
  diag_odd_chk: assert property (@(posedge clk) disable iff (rst)
    (out_amp == 2'd2) |-> out_phase[0]);

  // R7
  axis_even_chk: assert property (@(posedge clk) disable iff (rst)
    (out_amp == 2'd1) |-> !out_phase[0]);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_amp) && $stable(out_phase)));

  // R6
  origin_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && map_code.origin) |=> $stable(out_phase));

endmodule

// File: tb/sim_iq_polar_encoder.sv
module sim_iq_polar_encoder;

  localparam int W    = 4;
  localparam int FULL = 1 << (W - 1);
  localparam int HALF = 1 << (W - 2);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_i = '0;
  logic [W-1:0] in_q = '0;
  logic         out_valid;
  logic [1:0]   out_amp;
  logic [2:0]   out_phase;

  int n_chk  = 0;
  int n_fail = 0;
  int acc_i  = 0;
  int acc_q  = 0;
  int e_amp  = 0;
  int e_ph   = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  iq_polar_encoder #(.SAMPLE_W(W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_amp(out_amp), .out_phase(out_phase)
  );

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int quant(inout int acc, input int x);
    int v;
    v = acc + x;
    if (v > HALF)       begin acc = v - FULL; return 1;  end
    else if (v < -HALF) begin acc = v + FULL; return -1; end
    else                begin acc = v;        return 0;  end
  endfunction

  function automatic int phase_of(int a, int b);
    if (a ==  1 && b ==  0) return 0;
    if (a ==  1 && b ==  1) return 1;
    if (a ==  0 && b ==  1) return 2;
    if (a == -1 && b ==  1) return 3;
    if (a == -1 && b ==  0) return 4;
    if (a == -1 && b == -1) return 5;
    if (a ==  0 && b == -1) return 6;
    return 7;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // called at a negedge; drives one cycle and checks at the following negedge
  task automatic push(int x, int y, bit v, string req);
    int a;
    int b;
    in_i = W'(x);
    in_q = W'(y);
    in_valid = v;
    if (v) begin
      a = quant(acc_i, x);
      b = quant(acc_q, y);
      e_amp = (a != 0 ? 1 : 0) + (b != 0 ? 1 : 0);
      if (e_amp != 0) e_ph = phase_of(a, b);
    end
    @(negedge clk);
    chk({req, " R2 valid"}, int'(out_valid), int'(v));
    chk({req, " R4 amp"}, int'(out_amp), e_amp);
    chk({req, " R5 R6 phase"}, int'(out_phase), e_ph);
  endtask

  task automatic do_reset(int cycles);
    rst = 1'b1;
    in_valid = 1'b1;
    in_i = W'(FULL - 1);
    in_q = W'(-FULL);
    repeat (cycles) @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    acc_i = 0; acc_q = 0; e_amp = 0; e_ph = 0;
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 amp", int'(out_amp), 0);
    chk("R1 phase", int'(out_phase), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    @(negedge clk);
    do_reset(3);
    // R3 tie at exactly +H stays zero, then H+1 crosses
    push(HALF, 0, 1'b1, "R3 tie");
    chk("R3 tie amp zero", int'(out_amp), 0);
    do_reset(1);
    push(HALF + 1, -HALF - 1, 1'b1, "R3 cross");
    chk("R3 cross phase", int'(out_phase), 7);
    do_reset(1);
    push(-HALF, HALF, 1'b1, "R3 tie neg");
    // R6 origin after a non-zero code keeps phase
    do_reset(1);
    push(FULL - 1, FULL - 1, 1'b1, "R6 prime");
    push(0, 0, 1'b1, "R6 hold");
    // exhaustive sweep of all input pairs, three samples each, with gaps
    for (int x = -FULL; x < FULL; x++) begin
      for (int y = -FULL; y < FULL; y++) begin
        push(x, y, 1'b1, "sweep");
        push(x, y, 1'b1, "sweep");
        push(x, y, 1'b1, "sweep");
        if (((x + y) & 7) == 0) push(-x - 1, y ^ 3, 1'b0, "R8 idle");
      end
    end
    // R9 sustained most-negative input
    do_reset(2);
    for (int k = 0; k < 20; k++) begin
      push(-FULL, -FULL, 1'b1, "R9 floor");
      chk("R9 floor phase", int'(out_phase), 5);
    end
    // mid-run reset then a fresh ramp
    do_reset(1);
    for (int k = -FULL; k < FULL; k++) push(k, -k - 1, 1'b1, "R1 after reset");
    summary();
  end

endmodule